// File: doc/BRIEF.md
# GPIO Event and Interrupt Detector

This block watches a vector of input data bits that a GPIO core has already corrected for polarity, one bit per pin. It records events in sticky status bits and raises a single interrupt line. Each pin can be set to fire on a high level, on a rising edge, or on any change. A small write port reaches the configuration registers: event type, edge selection, enable, and status. The enable register also has separate set and clear addresses. A combinational read port returns the readable registers.

Edges are found by comparing the input vector with a copy of itself registered one clock earlier. Configuration writes only change how the next input sample is judged. They never look like an edge, but a level condition is checked again as soon as the new configuration applies. Software clears a status bit by writing one to it. If a level-mode pin is still high when it is cleared, its status bit comes back at once.

Top module: `gpio_event_unit`

## Requirements
- R1: After reset, the type, both-edge, enable and status registers all read zero, the history copy is zero, and the interrupt is low.
- R2: When a pin's type bit is 0 (level mode), its status bit is set at the first clock edge at which its input bit is 1.
- R3: When a pin's type bit is 1 and its both-edge bit is 0, only a 0-to-1 change of its input bit between consecutive clock edges sets its status bit. A 1-to-0 change sets nothing.
- R4: When a pin's type bit is 1 and its both-edge bit is 1, any change of its input bit between consecutive clock edges sets its status bit.
- R5: A status bit stays set after the condition that set it has gone away.
- R6: Writing the status register (byte offset 0x4C) clears each bit written as 1. Bits written as 0 keep their value.
- R7: A level-mode status bit that is cleared while its input is still 1 reads back as 1.
- R8: When a status clear and a new event for the same bit fall in the same cycle, the bit remains set.
- R9: Writing the type (0x28) or both-edge (0x2C) register never produces an edge event. A pin that is changed to level mode while its input is 1 gets its status bit set.
- R10: The interrupt is high exactly when some bit is set in both status and enable.
- R11: A write to offset 0x44 ORs the data into enable, and a write to 0x48 clears the enable bits written as 1. Both addresses read as zero. Enable itself is at 0x40.
- R12: Offsets other than 0x28, 0x2C, 0x40, 0x44, 0x48 and 0x4C read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_i | input | NPINS | Polarity-corrected input data, one bit per pin |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | ADDR_W | Byte offset of the write |
| wr_data_i | input | NPINS | Write data |
| rd_addr_i | input | ADDR_W | Byte offset of the read |
| rd_data_o | output | NPINS | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a status clear that lands in the same cycle as a new edge on the same pin. The bench drives the pin's input rise and the clear write on the same falling clock edge, so both are seen at one rising edge. It uses an edge-mode pin for this, so a later level re-evaluation cannot hide a lost event. It also rewrites the type and both-edge registers while inputs stay high, to show that configuration alone creates no edge but does re-trigger level mode.

// File: rtl/evt_pkg.sv
package evt_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TYPE,
    SEL_BOTH,
    SEL_EN,
    SEL_EN_SET,
    SEL_EN_CLR,
    SEL_STAT
  } evt_sel_e;

  localparam logic [31:0] OFS_TYPE   = 32'h28;
  localparam logic [31:0] OFS_BOTH   = 32'h2C;
  localparam logic [31:0] OFS_EN     = 32'h40;
  localparam logic [31:0] OFS_EN_SET = 32'h44;
  localparam logic [31:0] OFS_EN_CLR = 32'h48;
  localparam logic [31:0] OFS_STAT   = 32'h4C;

  // Map a byte offset to the register it selects.
  function automatic evt_sel_e evt_decode(input logic [31:0] a);
    evt_sel_e s;
    case (a)
      OFS_TYPE:   s = SEL_TYPE;
      OFS_BOTH:   s = SEL_BOTH;
      OFS_EN:     s = SEL_EN;
      OFS_EN_SET: s = SEL_EN_SET;
      OFS_EN_CLR: s = SEL_EN_CLR;
      OFS_STAT:   s = SEL_STAT;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

  // Trigger condition for one pin from its mode bits and two samples.
  function automatic logic evt_fires(input logic ty, input logic both,
                                     input logic cur, input logic prev);
    logic f;
    if (!ty)       f = cur;
    else if (both) f = cur ^ prev;
    else           f = cur & ~prev;
    return f;
  endfunction

endpackage

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
  import evt_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  evt_sel_e         sel,
  input  logic [NPINS-1:0] wr_data,
  output logic [NPINS-1:0] type_o,
  output logic [NPINS-1:0] both_o,
  output logic [NPINS-1:0] en_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_o <= '0;
      both_o <= '0;
      en_o   <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_TYPE:   type_o <= wr_data;
        SEL_BOTH:   both_o <= wr_data;
        SEL_EN:     en_o   <= wr_data;
        SEL_EN_SET: en_o   <= en_o | wr_data;
        SEL_EN_CLR: en_o   <= en_o & ~wr_data;
        default: ;
      endcase
    end
  end

  // R11: set alias leaves every written-one bit enabled
  p_en_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_EN_SET) |=> ((en_o & $past(wr_data)) == $past(wr_data)));

  // R11: clear alias leaves every written-one bit disabled
  p_en_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_EN_CLR) |=> ((en_o & $past(wr_data)) == '0));

  // R12: an unmapped write changes no configuration
  p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || sel == SEL_NONE || sel == SEL_STAT)
      |=> ($stable(type_o) && $stable(both_o) && $stable(en_o)));

endmodule

// File: rtl/evt_pin_cell.sv
module evt_pin_cell
  import evt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  input  logic prev,
  input  logic ty,
  input  logic both,
  input  logic clr,
  output logic set_o,
  output logic status_o
);

  assign set_o = evt_fires(ty, both, cur, prev);

  // A new event outranks a clear landing in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= 1'b0;
    else        status_o <= (status_o & ~clr) | set_o;
  end

  p_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ty && cur) |=> status_o);

  p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ty && !both && !prev && cur) |=> status_o);

  p_no_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ty && !both && !(cur && !prev) && !status_o) |=> !status_o);

  p_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ty && both && (cur != prev)) |=> status_o);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o && !clr) |=> status_o);

  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_o) |=> !status_o);

  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_o) |=> status_o);

endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit
  import evt_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  din_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NPINS-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [NPINS-1:0]  rd_data_o,
  output logic              irq_o
);

  localparam int ADDR_EXT = 32 - ADDR_W;

  evt_sel_e         wr_sel;
  evt_sel_e         rd_sel;
  logic [NPINS-1:0] din_hist;
  logic [NPINS-1:0] type_r;
  logic [NPINS-1:0] both_r;
  logic [NPINS-1:0] en_r;
  logic [NPINS-1:0] clr_vec;
  logic [NPINS-1:0] set_vec;
  logic [NPINS-1:0] status_r;

  assign wr_sel  = evt_decode({{ADDR_EXT{1'b0}}, wr_addr_i});
  assign rd_sel  = evt_decode({{ADDR_EXT{1'b0}}, rd_addr_i});
  assign clr_vec = (wr_en_i && wr_sel == SEL_STAT) ? wr_data_i : '0;

  // Input history for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_hist <= '0;
    else        din_hist <= din_i;
  end

  evt_cfg_regs #(.NPINS(NPINS)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .sel     (wr_sel),
    .wr_data (wr_data_i),
    .type_o  (type_r),
    .both_o  (both_r),
    .en_o    (en_r)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    evt_pin_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur      (din_i[p]),
      .prev     (din_hist[p]),
      .ty       (type_r[p]),
      .both     (both_r[p]),
      .clr      (clr_vec[p]),
      .set_o    (set_vec[p]),
      .status_o (status_r[p])
    );
  end

  assign irq_o = |(status_r & en_r);

  always_comb begin
    case (rd_sel)
      SEL_TYPE: rd_data_o = type_r;
      SEL_BOTH: rd_data_o = both_r;
      SEL_EN:   rd_data_o = en_r;
      SEL_STAT: rd_data_o = status_r;
      default:  rd_data_o = '0;
    endcase
  end

  // R10: an event on an enabled pin raises the interrupt on the next cycle
  p_evt_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(set_vec & en_r)) && !wr_en_i) |=> irq_o);

  // R10: writing enable to zero drops the interrupt
  p_en_zero_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel == SEL_EN && wr_data_i == '0) |=> !irq_o);

endmodule

// File: tb/tb_gpio_event_unit.sv
module tb_gpio_event_unit;

  localparam int NPINS  = 32;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NPINS-1:0]  din = '0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [NPINS-1:0]  wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [NPINS-1:0]  rd_data;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [ADDR_W-1:0] A_TYPE = 12'h028;
  localparam logic [ADDR_W-1:0] A_BOTH = 12'h02C;
  localparam logic [ADDR_W-1:0] A_EN   = 12'h040;
  localparam logic [ADDR_W-1:0] A_ENS  = 12'h044;
  localparam logic [ADDR_W-1:0] A_ENC  = 12'h048;
  localparam logic [ADDR_W-1:0] A_STAT = 12'h04C;

  always #2 clk = ~clk;

  gpio_event_unit #(.NPINS(NPINS), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .din_i(din), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_din(input logic [31:0] v);
    @(negedge clk);
    din = v;
    @(negedge clk);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_TYPE, d); chk("R1 type", d, 0);
    rd(A_BOTH, d); chk("R1 both", d, 0);
    rd(A_EN, d);   chk("R1 enable", d, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    set_din(32'h8);
    rd(A_STAT, d); chk("R2 level sets", d, 32'h8);
    chk("R10 irq low while disabled", irq, 0);
    set_din(32'h0);
    rd(A_STAT, d); chk("R5 sticky", d, 32'h8);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R6 write zero keeps", d, 32'h8);
    wr(A_STAT, 32'h8);
    rd(A_STAT, d); chk("R6 write one clears", d, 32'h0);
    wr(A_ENS, 32'h8);
    rd(A_EN, d);  chk("R11 set alias", d, 32'h8);
    rd(A_ENS, d); chk("R11 set alias reads zero", d, 0);
    rd(A_ENC, d); chk("R11 clear alias reads zero", d, 0);
    chk("R10 irq low with no status", irq, 0);
    set_din(32'h8);
    chk("R10 irq high", irq, 1);
    wr(A_STAT, 32'h8);
    rd(A_STAT, d); chk("R7 level re-asserts", d, 32'h8);
    wr(A_ENC, 32'h8);
    rd(A_EN, d); chk("R11 clear alias", d, 0);
    chk("R10 irq low after disable", irq, 0);
    set_din(32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R6 cleared", d, 0);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wr(A_TYPE, 32'h0000_00F0);
    wr(A_BOTH, 32'h0000_00C0);
    set_din(32'h50);
    rd(A_STAT, d); chk("R3 R4 rise", d, 32'h50);
    wr(A_STAT, 32'hFFFF_FFFF);
    set_din(32'h00);
    rd(A_STAT, d); chk("R3 R4 fall only both-edge", d, 32'h40);
    wr(A_STAT, 32'hFFFF_FFFF);
    set_din(32'hA0);
    rd(A_STAT, d); chk("R3 R4 rise other pins", d, 32'hA0);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R3 no event on steady high", d, 0);
  endtask

  task automatic t_cfg_no_edge();
    logic [31:0] d;
    wr(A_BOTH, 32'h0000_00E0);
    rd(A_STAT, d); chk("R9 both-edge write no event", d, 0);
    wr(A_TYPE, 32'h0000_00D0);
    rd(A_STAT, d); chk("R9 switch to level re-evaluates", d, 32'h20);
    set_din(32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(A_TYPE, 32'h0000_0200);
    wr(A_BOTH, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
    set_din(32'h200);
    rd(A_STAT, d); chk("R3 rise pin 9", d, 32'h200);
    set_din(32'h0);
    rd(A_STAT, d); chk("R5 held after fall", d, 32'h200);
    @(negedge clk);
    din = 32'h200; wr_en = 1'b1; wr_addr = A_STAT; wr_data = 32'h200;
    @(negedge clk);
    wr_en = 1'b0;
    rd(A_STAT, d); chk("R8 event wins over clear", d, 32'h200);
    wr(A_STAT, 32'h200);
    rd(A_STAT, d); chk("R6 clear on steady edge pin", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(A_EN, 32'h0000_1234);
    wr(12'h030, 32'hFFFF_FFFF);
    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h030, d); chk("R12 unmapped reads zero", d, 0);
    rd(12'h050, d); chk("R12 unmapped reads zero 2", d, 0);
    rd(A_EN, d);    chk("R12 enable untouched", d, 32'h0000_1234);
    rd(A_TYPE, d);  chk("R12 type untouched", d, 32'h0000_0200);
    rd(A_STAT, d);  chk("R12 status untouched", d, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_level();
    t_edges();
    t_cfg_no_edge();
    t_race();
    t_unmapped();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule